// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block converts one word offered on a valid/ready request port into one write cycle on an asynchronous 16-bit parallel panel bus. The cycle follows the conventions of a static-memory controller: an active-low select and an active-low write strobe frame the transfer, and a single register-select line tells the panel whether the word is a command or pixel/parameter data. The read strobe is driven inactive permanently because the engine only writes.

Each write has two programmable phases, both counted in clock cycles. The address phase has select low and write strobe high. It may be zero cycles long, since the panel samples the register-select line and the data lines together on the rising write strobe. The data phase has the write strobe low for the programmed value plus one cycles. A recovery cycle with select high always follows. The phase settings are sampled when a request is accepted.

The controller has four states. `ST_IDLE` is ready. On a handshake it goes to `ST_ADDR`, or straight to `ST_DATA` when the address setting is zero. `ST_ADDR` moves to `ST_DATA` when its count runs out. `ST_DATA` moves to `ST_RECOVER` when its count runs out. `ST_RECOVER` always returns to `ST_IDLE` after one cycle.

Top module: `lcd_wr_engine`

## Requirements
- R1: After reset the select and write strobes are high and `req_ready` is high.
- R2: `lcd_oe_n` is high in every cycle.
- R3: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the engine is back in its idle state, and it is low in every cycle that `lcd_cs_n` is low.
- R4: `lcd_cs_n` falls together with the start of the address phase. `lcd_rs` then equals the accepted `req_is_data` (1 = data register, 0 = command register). The address phase (select low, write strobe high) lasts exactly `cfg_addr_setup` cycles. With a setting of 0, select and write strobe fall in the same cycle.
- R5: `lcd_we_n` stays low for exactly `cfg_data_setup` + 1 consecutive cycles.
- R6: While `lcd_we_n` is low, `lcd_data` equals the accepted `req_word` and does not change, and `lcd_rs` does not change.
- R7: `lcd_we_n` is never low while `lcd_cs_n` is high, and both rise in the same cycle.
- R8: After each write, `lcd_cs_n` stays high for at least two cycles before it falls again.
- R9: Changing `cfg_addr_setup` or `cfg_data_setup` after a request has been accepted has no effect on that write.
- R10: If `req_valid` is held through a series of requests, each accepted word appears on the bus exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_word | input | DATA_W | Word to write |
| req_is_data | input | 1 | 1 = data register, 0 = command register |
| cfg_addr_setup | input | CNT_W | Address phase length in cycles (0 allowed) |
| cfg_data_setup | input | CNT_W | Data phase length minus one, in cycles |
| lcd_cs_n | output | 1 | Active-low chip select |
| lcd_we_n | output | 1 | Active-low write strobe |
| lcd_oe_n | output | 1 | Active-low read strobe, held high |
| lcd_rs | output | 1 | Register select address line |
| lcd_data | output | DATA_W | Parallel data bus |

## Verification
The assertions check several rules on every cycle: the strobes stay nested, the select gap is respected, ready stays low while busy, the bus is stable under the write strobe, and the accepted word and flag appear on the bus. A counter inside the checker also measures both phase lengths against the settings that were captured at the handshake. Some behaviour only the bench scenarios can show. These include the reset state, the permanently idle read strobe, settings being ignored once they change mid-transfer, the extreme settings, and the end-to-end ordering and count of words in a back-to-back burst. The bench shows these by comparing every observed bus cycle with a queue of expected writes.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR    = 2'd1,
        ST_DATA    = 2'd2,
        ST_RECOVER = 2'd3
    } lcdw_state_e;

    function automatic logic sel_active(input lcdw_state_e s);
        return (s == ST_ADDR) || (s == ST_DATA);
    endfunction

    function automatic logic strobe_active(input lcdw_state_e s);
        return (s == ST_DATA);
    endfunction

endpackage

// File: rtl/lcdw_capture.sv
module lcdw_capture #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] in_word,
    input  logic              in_is_data,
    input  logic [CNT_W-1:0]  in_data_setup,
    output logic [DATA_W-1:0] word_q,
    output logic              is_data_q,
    output logic [CNT_W-1:0]  data_setup_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q       <= '0;
            is_data_q    <= 1'b0;
            data_setup_q <= '0;
        end else if (load) begin
            word_q       <= in_word;
            is_data_q    <= in_is_data;
            data_setup_q <= in_data_setup;
        end
    end

endmodule

// File: rtl/lcdw_phase_cnt.sv
module lcdw_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/lcdw_fsm.sv
module lcdw_fsm
    import lcdw_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] cfg_addr_setup,
    input  logic [CNT_W-1:0] cfg_data_setup,
    input  logic [CNT_W-1:0] lat_data_setup,
    input  logic             cnt_zero,
    output logic             req_ready,
    output logic             cap_load,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_load_val,
    output logic             cnt_dec,
    output logic             cs_n,
    output logic             we_n
);

    lcdw_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and phase counter control
    always_comb begin
        state_d      = state_q;
        cap_load     = 1'b0;
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        cnt_dec      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cap_load = 1'b1;
                    cnt_load = 1'b1;
                    if (cfg_addr_setup != '0) begin
                        state_d      = ST_ADDR;
                        cnt_load_val = cfg_addr_setup - CNT_W'(1);
                    end else begin
                        state_d      = ST_DATA;
                        cnt_load_val = cfg_data_setup;
                    end
                end
            end
            ST_ADDR: begin
                if (cnt_zero) begin
                    state_d      = ST_DATA;
                    cnt_load     = 1'b1;
                    cnt_load_val = lat_data_setup;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_DATA: begin
                if (cnt_zero) begin
                    state_d = ST_RECOVER;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_RECOVER: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered strobes, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            we_n <= 1'b1;
        end else begin
            cs_n <= !sel_active(state_d);
            we_n <= !strobe_active(state_d);
        end
    end

    assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/lcd_wr_engine.sv
module lcd_wr_engine #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_word,
    input  logic              req_is_data,
    input  logic [CNT_W-1:0]  cfg_addr_setup,
    input  logic [CNT_W-1:0]  cfg_data_setup,
    output logic              lcd_cs_n,
    output logic              lcd_we_n,
    output logic              lcd_oe_n,
    output logic              lcd_rs,
    output logic [DATA_W-1:0] lcd_data
);

    logic             cap_load;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic [CNT_W-1:0] lat_data_setup;

    lcdw_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .cfg_addr_setup (cfg_addr_setup),
        .cfg_data_setup (cfg_data_setup),
        .lat_data_setup (lat_data_setup),
        .cnt_zero       (cnt_zero),
        .req_ready      (req_ready),
        .cap_load       (cap_load),
        .cnt_load       (cnt_load),
        .cnt_load_val   (cnt_load_val),
        .cnt_dec        (cnt_dec),
        .cs_n           (lcd_cs_n),
        .we_n           (lcd_we_n)
    );

    lcdw_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero)
    );

    lcdw_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (cap_load),
        .in_word       (req_word),
        .in_is_data    (req_is_data),
        .in_data_setup (cfg_data_setup),
        .word_q        (lcd_data),
        .is_data_q     (lcd_rs),
        .data_setup_q  (lat_data_setup)
    );

    assign lcd_oe_n = 1'b1;

endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DATA_W-1:0] req_word,
    input logic              req_is_data,
    input logic [CNT_W-1:0]  cfg_addr_setup,
    input logic [CNT_W-1:0]  cfg_data_setup,
    input logic              lcd_cs_n,
    input logic              lcd_we_n,
    input logic              lcd_oe_n,
    input logic              lcd_rs,
    input logic [DATA_W-1:0] lcd_data
);

    logic [CNT_W-1:0] a_lat, d_lat;
    logic [CNT_W:0]   addr_cnt, low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_lat    <= '0;
            d_lat    <= '0;
            addr_cnt <= '0;
            low_cnt  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                a_lat <= cfg_addr_setup;
                d_lat <= cfg_data_setup;
            end
            if (lcd_cs_n)       addr_cnt <= '0;
            else if (lcd_we_n)  addr_cnt <= addr_cnt + 1'b1;
            if (lcd_we_n)       low_cnt  <= '0;
            else                low_cnt  <= low_cnt + 1'b1;
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_cs_n |-> !req_ready); // R3
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R3
    AST_WORD_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (lcd_data == $past(req_word) && lcd_rs == $past(req_is_data))); // R4
    AST_ADDR_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_we_n) |-> (addr_cnt == {1'b0, a_lat})); // R4
    AST_DATA_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_we_n) |-> (low_cnt == ({1'b0, d_lat} + 1'b1))); // R5
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_we_n && $past(!lcd_we_n)) |-> ($stable(lcd_data) && $stable(lcd_rs))); // R6
    AST_STROBE_INSIDE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_we_n |-> !lcd_cs_n); // R7
    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_we_n) |-> $rose(lcd_cs_n)); // R7
    AST_SEL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_cs_n) |=> lcd_cs_n); // R8

endmodule

bind lcd_wr_engine lcdw_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_lcd_wr_engine.sv
module tb_lcd_wr_engine;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 4;

    typedef struct {
        logic [DATA_W-1:0] w;
        logic              rs;
        int                a;
        int                d;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [DATA_W-1:0] req_word = '0;
    logic              req_is_data = 1'b0;
    logic [CNT_W-1:0]  cfg_addr_setup = '0;
    logic [CNT_W-1:0]  cfg_data_setup = '0;
    logic              lcd_cs_n, lcd_we_n, lcd_oe_n, lcd_rs;
    logic [DATA_W-1:0] lcd_data;

    int   checks = 0;
    int   fails  = 0;
    int   sent   = 0;
    int   seen   = 0;
    bit   oe_bad = 0;
    bit   done   = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    lcd_wr_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Driver: pushes expectation, offers request, scrambles settings after accept (R9)
    task automatic send(input logic [DATA_W-1:0] w, input logic rs, input int a, input int d);
        exp_t e;
        e.w = w; e.rs = rs; e.a = a; e.d = d;
        q.push_back(e);
        sent++;
        req_word       = w;
        req_is_data    = rs;
        cfg_addr_setup = CNT_W'(a);
        cfg_data_setup = CNT_W'(d);
        req_valid      = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid      = 1'b0;
        req_word       = ~w;
        req_is_data    = ~rs;
        cfg_addr_setup = ~CNT_W'(a);
        cfg_data_setup = ~CNT_W'(d);
    endtask

    // Monitor: measures each bus cycle and compares with the queue head
    initial begin
        bit                in_cs = 0;
        bit                stab_bad = 0;
        bit                rdy_bad = 0;
        bit                last_we_low = 0;
        bit                we_outside = 0;
        int                addr_c = 0;
        int                data_c = 0;
        int                gap = 100;
        logic [DATA_W-1:0] w0 = '0;
        logic              r0 = 1'b0;
        exp_t              e;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (lcd_oe_n !== 1'b1) oe_bad = 1;
            if (!lcd_we_n && lcd_cs_n) we_outside = 1;
            if (!lcd_cs_n) begin
                if (!in_cs) begin
                    in_cs = 1;
                    chk(gap >= 2, "R8", "select high gap", gap, 2);
                    addr_c = 0; data_c = 0; stab_bad = 0; rdy_bad = 0;
                end
                if (req_ready) rdy_bad = 1;
                if (lcd_we_n) addr_c++;
                else begin
                    if (data_c == 0) begin w0 = lcd_data; r0 = lcd_rs; end
                    else if (lcd_data !== w0 || lcd_rs !== r0) stab_bad = 1;
                    data_c++;
                end
                last_we_low = !lcd_we_n;
            end else begin
                if (in_cs) begin
                    in_cs = 0;
                    gap = 0;
                    seen++;
                    chk(last_we_low, "R7", "strobe and select rise together", int'(last_we_low), 1);
                    chk(!rdy_bad, "R3", "ready low while busy", int'(rdy_bad), 0);
                    chk(!stab_bad, "R6", "bus stable under strobe", int'(stab_bad), 0);
                    if (q.size() == 0) begin
                        chk(0, "R10", "unexpected extra write", seen, sent);
                    end else begin
                        e = q.pop_front();
                        chk(w0 === e.w, "R6", "word on bus", int'(w0), int'(e.w));
                        chk(r0 === e.rs, "R4", "register select", int'(r0), int'(e.rs));
                        chk(addr_c == e.a, "R4 R9", "address phase cycles", addr_c, e.a);
                        chk(data_c == e.d + 1, "R5 R9", "strobe low cycles", data_c, e.d + 1);
                    end
                end
                gap++;
            end
            if (done) break;
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lcd_cs_n === 1'b1 && lcd_we_n === 1'b1, "R1", "strobes high in reset", int'({lcd_cs_n, lcd_we_n}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        chk(lcd_cs_n === 1'b1 && lcd_we_n === 1'b1, "R1", "strobes after reset", int'({lcd_cs_n, lcd_we_n}), 3);

        // Zero address phase, data register
        send(16'hA5C3, 1'b1, 0, 2);
        repeat (6) @(negedge clk);
        // Command with address phase, minimum data phase
        send(16'h002A, 1'b0, 3, 0);
        repeat (6) @(negedge clk);
        send(16'h1234, 1'b1, 1, 5);
        repeat (10) @(negedge clk);
        // Extreme settings
        send(16'hFFFF, 1'b0, 15, 15);
        send(16'h0000, 1'b1, 0, 0);
        // Back-to-back burst with valid held (R10)
        send(16'h002C, 1'b0, 0, 1);
        for (int i = 0; i < 6; i++) send(16'(16'h0F00 + i * 16'h0111), 1'b1, i % 3, (i * 5) % 4);
        repeat (40) @(negedge clk);

        chk(q.size() == 0, "R10", "writes left pending", q.size(), 0);
        chk(seen == sent, "R10", "write count", seen, sent);
        chk(!oe_bad, "R2", "read strobe high always", int'(oe_bad), 0);
        done = 1;
        summary();
    end

endmodule